// File: doc/BRIEF.md
# PCI INTx Line Request Controller

This block sits between a PCI function's interrupt request and its legacy INTx output pin, one independent controller per function. Each function raises and lowers a level request. The controller drives the INTx line only while the function is allowed to interrupt. A request that arrives while interrupts are blocked is remembered and is replayed once permission returns. A request that is blocked after it has been driven is withdrawn from the pin and held until permission returns.

Interrupts are blocked while the function's command-register INTx-disable bit is set. When the parameter `MSI_GATE` is 1, they are also blocked while MSI or MSI-X is enabled. A status bit per function mirrors the PCI interrupt-status semantics: it is 1 whenever a request is outstanding, whether or not the request is reaching the pin.

The parameter `NUM_FUNC` (1 to 8) sets how many functions are served. Bit i of every vector port belongs to function i.

Top module: `intx_line_ctrl`

## Requirements
- R1: Reset (rst_n low, asynchronous) puts every function in IDLE, with intx_o = 0 and int_sts_o = 0.
- R2: A request (req_i = 1) seen in IDLE while permitted moves the function to ASSERTED; intx_o and int_sts_o read 1 after that clock edge.
- R3: A request seen in IDLE while not permitted moves the function to PENDING; intx_o stays 0 and int_sts_o reads 1.
- R4: Dropping the request (req_i = 0) in ASSERTED returns the function to IDLE; both outputs read 0 after the edge.
- R5: Dropping the request in PENDING returns the function to IDLE; intx_o stays 0 throughout and int_sts_o clears.
- R6: Loss of permission in ASSERTED, with the request still high, drops intx_o and moves the function to PENDING; int_sts_o stays 1.
- R7: Regaining permission in PENDING, with the request still high, moves the function to ASSERTED and drives intx_o to 1.
- R8: A function is permitted only when intx_dis_i is 0 and, if MSI_GATE = 1, msi_en_i is also 0. Either bit alone blocks it.
- R9: int_sts_o is 1 exactly when the function is in ASSERTED or PENDING, and intx_o is 1 exactly in ASSERTED.
- R10: If the request drops in the same cycle that permission changes, the drop wins and the function goes to IDLE.
- R11: Functions are independent: the inputs of bit i affect only the outputs of bit i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | NUM_FUNC | Level interrupt request per function |
| intx_dis_i | input | NUM_FUNC | Command-register INTx-disable bit per function |
| msi_en_i | input | NUM_FUNC | MSI or MSI-X enabled per function |
| intx_o | output | NUM_FUNC | INTx assert level per function |
| int_sts_o | output | NUM_FUNC | Interrupt-status bit per function |

## Verification
All inputs are sampled at a rising edge, and both outputs come straight from the state register, so every result is due exactly one clock after the edge that samples its stimulus. The bench changes inputs at the falling edge. Its reference model advances at the next rising edge, and the outputs are compared with the model at the falling edge that follows. Every cycle is therefore checked at the single point where its result is due. Directed sequences reach each transition and each same-cycle conflict; a long random phase then exercises all functions at once with independent stimulus.

// File: rtl/intx_line_pkg.sv
package intx_line_pkg;
   typedef enum logic [1:0] {
      ST_IDLE     = 2'd0,
      ST_ASSERTED = 2'd1,
      ST_PENDING  = 2'd2
   } line_state_e;

   localparam int MAX_FUNC = 8;
endpackage

// File: rtl/intx_permit.sv
module intx_permit #(
   parameter bit MSI_GATE = 1'b1
) (
   input  logic intx_dis_i,
   input  logic msi_en_i,
   output logic permit_o
);
   generate
      if (MSI_GATE) begin : g_msi_gate
         assign permit_o = ~intx_dis_i & ~msi_en_i;
      end else begin : g_no_msi_gate
         logic unused_msi;
         assign unused_msi = msi_en_i;
         assign permit_o   = ~intx_dis_i;
      end
   endgenerate
endmodule

// File: rtl/intx_line_fsm.sv
module intx_line_fsm
   import intx_line_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic req_i,
   input  logic permit_i,
   output logic intx_o,
   output logic sts_o
);
   line_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE: begin
            if (req_i) state_d = permit_i ? ST_ASSERTED : ST_PENDING;
         end
         ST_ASSERTED: begin
            if (!req_i)         state_d = ST_IDLE;
            else if (!permit_i) state_d = ST_PENDING;
         end
         ST_PENDING: begin
            if (!req_i)        state_d = ST_IDLE;
            else if (permit_i) state_d = ST_ASSERTED;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   assign intx_o = (state_q == ST_ASSERTED);
   assign sts_o  = (state_q != ST_IDLE);

   AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> !sts_o); // R1
   AST_GRANT_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i && permit_i) |=> intx_o); // R2
   AST_BLOCKED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i && !permit_i) |=> (!intx_o && sts_o)); // R3
   AST_DROP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      !req_i |=> (!intx_o && !sts_o)); // R4
   AST_PIN_IMPLIES_STS: assert property (@(posedge clk) disable iff (!rst_n)
      intx_o |-> sts_o); // R9
endmodule

// File: rtl/intx_line_ctrl.sv
module intx_line_ctrl
   import intx_line_pkg::*;
#(
   parameter int NUM_FUNC = 4,
   parameter bit MSI_GATE = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_FUNC-1:0] req_i,
   input  logic [NUM_FUNC-1:0] intx_dis_i,
   input  logic [NUM_FUNC-1:0] msi_en_i,
   output logic [NUM_FUNC-1:0] intx_o,
   output logic [NUM_FUNC-1:0] int_sts_o
);
   localparam int FuncIdxW = (NUM_FUNC > 1) ? $clog2(NUM_FUNC) : 1;

   generate
      if (NUM_FUNC < 1 || NUM_FUNC > MAX_FUNC) begin : g_bad_count
         $error("intx_line_ctrl: NUM_FUNC out of range");
      end
      if (FuncIdxW > 3) begin : g_bad_width
         $error("intx_line_ctrl: function index too wide");
      end
   endgenerate

   logic [NUM_FUNC-1:0] permit;

   generate
      for (genvar f = 0; f < NUM_FUNC; f++) begin : g_func
         intx_permit #(.MSI_GATE(MSI_GATE)) u_permit (
            .intx_dis_i (intx_dis_i[f]),
            .msi_en_i   (msi_en_i[f]),
            .permit_o   (permit[f])
         );

         intx_line_fsm u_fsm (
            .clk      (clk),
            .rst_n    (rst_n),
            .req_i    (req_i[f]),
            .permit_i (permit[f]),
            .intx_o   (intx_o[f]),
            .sts_o    (int_sts_o[f])
         );

         AST_DIS_BLOCKS_PIN: assert property (@(posedge clk) disable iff (!rst_n)
            intx_dis_i[f] |=> !intx_o[f]); // R8
      end
   endgenerate
endmodule

// File: tb/intx_line_ctrl_bench.sv
`timescale 1ns/1ps
module intx_line_ctrl_bench;
   localparam int NF = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NF-1:0] req = '0, dis = '0, msi = '0;
   logic [NF-1:0] intx, sts;

   int    n_cmp = 0, n_bad = 0;
   bit    finished = 0;
   int    mst [NF];
   string tag [NF];

   always #5 clk = ~clk;

   intx_line_ctrl #(.NUM_FUNC(NF), .MSI_GATE(1'b1)) u_intx_line_ctrl (
      .clk(clk), .rst_n(rst_n), .req_i(req), .intx_dis_i(dis),
      .msi_en_i(msi), .intx_o(intx), .int_sts_o(sts)
   );

   // Reference model: 0 idle, 1 driving the pin, 2 held back
   always @(posedge clk or negedge rst_n) begin
      for (int f = 0; f < NF; f++) begin
         bit perm;
         perm = !dis[f] && !msi[f];
         if (!rst_n) begin
            mst[f] = 0; tag[f] = "R1";
         end else begin
            case (mst[f])
               0: if (req[f]) begin
                     mst[f] = perm ? 1 : 2;
                     tag[f] = perm ? "R2" : ((msi[f] && !dis[f]) ? "R8" : "R3");
                  end else tag[f] = "R11";
               1: if (!req[f]) begin
                     mst[f] = 0; tag[f] = perm ? "R4" : "R10";
                  end else if (!perm) begin
                     mst[f] = 2; tag[f] = (msi[f] && !dis[f]) ? "R8" : "R6";
                  end else tag[f] = "R11";
               default: if (!req[f]) begin
                     mst[f] = 0; tag[f] = perm ? "R10" : "R5";
                  end else if (perm) begin
                     mst[f] = 1; tag[f] = "R7";
                  end else tag[f] = "R11";
            endcase
         end
      end
   end

   task automatic compare_all();
      for (int f = 0; f < NF; f++) begin
         bit ei, es;
         ei = (mst[f] == 1);
         es = (mst[f] != 0);
         n_cmp++;
         if (intx[f] !== ei) begin
            n_bad++;
            $display("FAIL %s f%0d intx_o: actual %b expected %b", tag[f], f, intx[f], ei);
         end
         n_cmp++;
         if (sts[f] !== es) begin
            n_bad++;
            $display("FAIL R9 (%s) f%0d int_sts_o: actual %b expected %b", tag[f], f, sts[f], es);
         end
      end
   endtask

   task automatic step(input logic [NF-1:0] r, input logic [NF-1:0] d, input logic [NF-1:0] m);
      req = r; dis = d; msi = m;
      @(negedge clk);
      compare_all();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      compare_all();                       // R1 reset state
      rst_n = 1'b1;
      @(negedge clk); compare_all();
      // R2: f0 permitted; R3: f1 disabled; R8: f2 msi only
      step(4'b0111, 4'b0010, 4'b0100);
      // R6 f0 loses permit; R7 f1 regains; f2 stays held
      step(4'b0111, 4'b0001, 4'b0100);
      // R7 for f0 again; R5 f2 drops while held
      step(4'b0011, 4'b0000, 4'b0100);
      // R4 f0 drop while driving
      step(4'b0010, 4'b0000, 4'b0000);
      // R10: f1 drops as permit is lost; f3 blocked by msi (R8)
      step(4'b1000, 4'b0010, 4'b1000);
      // R10: f3 drops as permit returns
      step(4'b0000, 4'b0000, 4'b0000);
      // repeated raise has no effect (R2 level)
      step(4'b0001, 4'b0000, 4'b0000);
      step(4'b0001, 4'b0000, 4'b0000);
      // R1 asynchronous reset mid-run
      rst_n = 1'b0; #1;
      @(negedge clk); compare_all();
      rst_n = 1'b1;
      // R11 random independent stimulus
      for (int c = 0; c < 4000; c++) begin
         logic [NF-1:0] r, d, m;
         r = req; d = dis; m = msi;
         for (int f = 0; f < NF; f++) begin
            if ($urandom_range(3) == 0) r[f] = ~r[f];
            if ($urandom_range(5) == 0) d[f] = ~d[f];
            if ($urandom_range(7) == 0) m[f] = ~m[f];
         end
         step(r, d, m);
      end
      if (!finished) begin
         finished = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_cmp++; n_bad++;
         $display("FAIL watchdog expired: actual running expected done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule